// File: doc/BRIEF.md
# Address Translation Cache with Page-Size Masks

This block is a small fully associative cache of virtual-to-physical page mappings for a three-level, 39-bit virtual address scheme with 56-bit physical addresses. Every entry carries a 16-bit address-space identifier, a global flag, a virtual page tag, a physical page base, the 8 attribute bits of the page-table entry and the physical address of that entry. Each entry also stores an offset mask that is set by the level of the page: 4 KiB, 2 MiB or 1 GiB. A single entry can therefore cover a whole superpage.

A core presents a virtual address and the current identifier on the lookup port. In the same cycle the block returns a hit flag, the slot number, the translated physical address, the attribute bits and the entry's own address. After a miss, the page walker writes its result through the fill port. Attribute bits of a valid slot, such as the accessed and dirty bits, can be rewritten in place through the update port. The invalidate port removes entries. It can select them by identifier, by address, by both, or select every entry, and global entries are kept when the identifier is part of the selection.

Top module: `xc_tlb`

## Requirements
- R1: After reset no slot is valid, so every lookup misses (`lk_hit`=0).
- R2: On a fill with level L (0, 1 or 2; 3 is not used), the offset mask is (1 << (12 + 9·L)) − 1. The page tag and the physical base are stored with their offset bits cleared. A later lookup hits when the address ANDed with the complement of the mask equals the tag, and `lk_pa` is the base ORed with (address AND mask), zero-extended.
- R3: A hit also requires that the entry is global or that its identifier equals `lk_asid`.
- R4: Lookup outputs are combinational on the stored state. A fill is visible to lookups from the cycle after it is accepted.
- R5: An invalidate with neither `fl_use_asid` nor `fl_use_va` set removes every entry in one cycle.
- R6: An invalidate by address only removes every entry whose tag matches `fl_va` under that entry's mask, global or not.
- R7: An invalidate by identifier only removes the non-global entries whose identifier equals `fl_asid`. Global entries stay.
- R8: An invalidate by both removes the non-global entries that match the identifier and the address.
- R9: An invalidate and a fill in the same cycle: the invalidate is applied and the fill is dropped.
- R10: A fill goes to the lowest-numbered invalid slot. If every slot is valid, it replaces the slot that was filled least recently. `lk_idx` reports the slot that hit.
- R11: An update writes `upd_pte` into slot `upd_idx` only if that slot is valid and neither an invalidate nor a fill is asserted in the same cycle. Otherwise it has no effect.
- R12: On a hit, `lk_pte` and `lk_pte_addr` return the stored attribute bits and the stored entry address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_asid | input | 16 | Current address-space identifier for lookup |
| lk_va | input | 39 | Virtual address to look up |
| lk_hit | output | 1 | A valid entry matches |
| lk_idx | output | 2 | Slot that matched |
| lk_pa | output | 56 | Translated physical address |
| lk_pte | output | 8 | Stored attribute bits of the matching entry |
| lk_pte_addr | output | 56 | Stored entry address of the matching entry |
| fill_en | input | 1 | Write a new mapping |
| fill_asid | input | 16 | Identifier of the new mapping |
| fill_glb | input | 1 | New mapping is global |
| fill_lvl | input | 2 | Page level: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_va | input | 39 | Virtual address that was walked |
| fill_pa | input | 56 | Physical address from the walk |
| fill_pte | input | 8 | Attribute bits of the leaf entry |
| fill_pte_addr | input | 56 | Physical address of the leaf entry |
| upd_en | input | 1 | Rewrite the attribute bits of one slot |
| upd_idx | input | 2 | Slot to rewrite |
| upd_pte | input | 8 | New attribute bits |
| fl_en | input | 1 | Invalidate request |
| fl_use_asid | input | 1 | Select by identifier |
| fl_asid | input | 16 | Identifier selector |
| fl_use_va | input | 1 | Select by address |
| fl_va | input | 39 | Address selector |

## Verification
The checker assumes that the mappings held at any time never overlap for one identifier. This means at most one slot hits, and the assertion on the hit vector depends on that. It also assumes that `fill_lvl` never takes the value 3. The stimulus respects both assumptions. Random fills use a distinct 1 GiB region for each mapping and are issued only when no valid entry occupies that region. Levels are drawn from 0 to 2. Directed fills use separate regions as well, so lookups in random and directed phases never see more than one candidate entry.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VA_W    = 39;
  localparam int PA_W    = 56;
  localparam int ASID_W  = 16;
  localparam int PTE_W   = 8;
  localparam int PG_SH   = 12;
  localparam int LVL_SH  = 9;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 3;

  typedef struct packed {
    logic              glb;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   omask;
    logic [PA_W-1:0]   ppn;
    logic [PTE_W-1:0]  pte;
    logic [PA_W-1:0]   pta;
  } xc_ent_t;

  // offset mask of a page at the given level
  function automatic logic [VA_W-1:0] off_mask(input logic [LVL_W-1:0] lvl);
    logic [VA_W:0] one;
    logic [VA_W:0] full;
    one  = {{VA_W{1'b0}}, 1'b1};
    full = (one << (PG_SH + LVL_SH * int'(lvl))) - one;
    return full[VA_W-1:0];
  endfunction
endpackage

// File: rtl/xc_match.sv
module xc_match
  import xc_pkg::*;
(
  input  logic              vld,
  input  logic              glb,
  input  logic [ASID_W-1:0] asid,
  input  logic [VA_W-1:0]   vpn,
  input  logic [VA_W-1:0]   omask,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              fl_use_asid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_use_va,
  input  logic [VA_W-1:0]   fl_va,
  output logic              hit,
  output logic              kill
);
  logic lk_tag_eq, lk_id_ok, fl_tag_eq, fl_id_ok;

  always_comb begin
    lk_tag_eq = (vpn == (lk_va & ~omask));
    lk_id_ok  = glb | (asid == lk_asid);
    hit       = vld & lk_tag_eq & lk_id_ok;
    fl_tag_eq = (vpn == (fl_va & ~omask));
    fl_id_ok  = ~glb & (asid == fl_asid);
    kill      = vld & (fl_use_va ? fl_tag_eq : 1'b1)
                    & (fl_use_asid ? fl_id_ok : 1'b1);
  end
endmodule

// File: rtl/xc_first.sv
module xc_first #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb
  import xc_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [((NUM_ENT > 1) ? $clog2(NUM_ENT) : 1)-1:0] lk_idx,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PTE_W-1:0]  lk_pte,
  output logic [PA_W-1:0]   lk_pte_addr,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_glb,
  input  logic [LVL_W-1:0]  fill_lvl,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic              upd_en,
  input  logic [((NUM_ENT > 1) ? $clog2(NUM_ENT) : 1)-1:0] upd_idx,
  input  logic [PTE_W-1:0]  upd_pte,
  input  logic              fl_en,
  input  logic              fl_use_asid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_use_va,
  input  logic [VA_W-1:0]   fl_va
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int EXT_W = PA_W - VA_W;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENT - 1);

  xc_ent_t            ent_q [NUM_ENT];
  xc_ent_t            ent_d [NUM_ENT];
  logic [IDX_W-1:0]   age_q [NUM_ENT];
  logic [IDX_W-1:0]   age_d [NUM_ENT];
  logic [NUM_ENT-1:0] vld_q, vld_d, hit_v, kill_v, free_v;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx, old_idx, vic;
  logic               fill_ok, upd_ok, vld_we, age_we, ent_we;
  logic [VA_W-1:0]    new_om;
  xc_ent_t            new_ent;
  xc_ent_t            sel;

  // per-slot match for lookup and invalidate
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    xc_match u_match (
      .vld         (vld_q[g]),
      .glb         (ent_q[g].glb),
      .asid        (ent_q[g].asid),
      .vpn         (ent_q[g].vpn),
      .omask       (ent_q[g].omask),
      .lk_asid     (lk_asid),
      .lk_va       (lk_va),
      .fl_use_asid (fl_use_asid),
      .fl_asid     (fl_asid),
      .fl_use_va   (fl_use_va),
      .fl_va       (fl_va),
      .hit         (hit_v[g]),
      .kill        (kill_v[g])
    );
  end

  xc_first #(.N(NUM_ENT), .W(IDX_W)) u_hit_pick (
    .req (hit_v),
    .any (lk_hit),
    .idx (lk_idx)
  );

  assign free_v = ~vld_q;

  xc_first #(.N(NUM_ENT), .W(IDX_W)) u_free_pick (
    .req (free_v),
    .any (free_any),
    .idx (free_idx)
  );

  // victim: lowest free slot, else the oldest fill
  always_comb begin
    old_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
    vic = free_any ? free_idx : old_idx;
  end

  always_comb begin
    new_om        = off_mask(fill_lvl);
    new_ent.glb   = fill_glb;
    new_ent.asid  = fill_asid;
    new_ent.vpn   = fill_va & ~new_om;
    new_ent.omask = new_om;
    new_ent.ppn   = fill_pa & ~{{EXT_W{1'b0}}, new_om};
    new_ent.pte   = fill_pte;
    new_ent.pta   = fill_pte_addr;
  end

  // clock enables
  always_comb begin
    fill_ok = fill_en & ~fl_en;
    upd_ok  = upd_en & ~fl_en & ~fill_en & vld_q[upd_idx];
    vld_we  = fl_en | fill_en;
    age_we  = fill_ok;
    ent_we  = fill_ok | upd_ok;
  end

  // next state
  always_comb begin
    vld_d = vld_q;
    ent_d = ent_q;
    age_d = age_q;
    if (fl_en) begin
      vld_d = vld_q & ~kill_v;
    end else if (fill_en) begin
      vld_d[vic] = 1'b1;
      ent_d[vic] = new_ent;
      for (int i = 0; i < NUM_ENT; i++) begin
        if (IDX_W'(i) == vic) age_d[i] = '0;
        else if (age_q[i] < age_q[vic]) age_d[i] = age_q[i] + 1'b1;
      end
    end else if (upd_ok) begin
      ent_d[upd_idx].pte = upd_pte;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) age_q[i] <= IDX_W'(i);
    end else begin
      if (vld_we) vld_q <= vld_d;
      if (age_we) age_q <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_we) ent_q <= ent_d;
  end

  // lookup result
  always_comb begin
    sel         = ent_q[lk_idx];
    lk_pa       = '0;
    lk_pte      = '0;
    lk_pte_addr = '0;
    if (lk_hit) begin
      lk_pa       = sel.ppn | {{EXT_W{1'b0}}, lk_va & sel.omask};
      lk_pte      = sel.pte;
      lk_pte_addr = sel.pta;
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk
  import xc_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ASID_W-1:0]  lk_asid,
  input logic [VA_W-1:0]    lk_va,
  input logic               lk_hit,
  input logic               fill_en,
  input logic [ASID_W-1:0]  fill_asid,
  input logic [VA_W-1:0]    fill_va,
  input logic [LVL_W-1:0]   fill_lvl,
  input logic               upd_en,
  input logic               fl_en,
  input logic               fl_use_asid,
  input logic               fl_use_va,
  input logic [NUM_ENT-1:0] vld_q,
  input logic [NUM_ENT-1:0] hit_v
);
  // R2: only three page levels exist
  p_lvl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (fill_lvl < LVL_W'(NUM_LVL)));

  // R2: non-overlapping mappings give at most one matching slot
  p_onehot_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));

  p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '0) |-> !lk_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fl_en) |=>
      ((lk_va != $past(fill_va)) || (lk_asid != $past(fill_asid)) || lk_hit));

  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_use_asid && !fl_use_va) |=> (vld_q == '0));

  p_flush_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> ($countones(vld_q) <= $countones($past(vld_q))));

  p_fill_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fl_en) |=> ($countones(vld_q) >= $countones($past(vld_q))));

  p_upd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !fl_en && !fill_en) |=> (vld_q == $past(vld_q)));
endmodule

bind xc_tlb xc_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_asid     (lk_asid),
  .lk_va       (lk_va),
  .lk_hit      (lk_hit),
  .fill_en     (fill_en),
  .fill_asid   (fill_asid),
  .fill_va     (fill_va),
  .fill_lvl    (fill_lvl),
  .upd_en      (upd_en),
  .fl_en       (fl_en),
  .fl_use_asid (fl_use_asid),
  .fl_use_va   (fl_use_va),
  .vld_q       (vld_q),
  .hit_v       (hit_v)
);

// File: tb/sim_xc_tlb.sv
module sim_xc_tlb;
  localparam int CLK_PER = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lk_asid;
  logic [38:0] lk_va;
  logic        lk_hit;
  logic [1:0]  lk_idx;
  logic [55:0] lk_pa, lk_pte_addr;
  logic [7:0]  lk_pte;
  logic        fill_en, fill_glb;
  logic [15:0] fill_asid;
  logic [1:0]  fill_lvl;
  logic [38:0] fill_va;
  logic [55:0] fill_pa, fill_pte_addr;
  logic [7:0]  fill_pte;
  logic        upd_en;
  logic [1:0]  upd_idx;
  logic [7:0]  upd_pte;
  logic        fl_en, fl_use_asid, fl_use_va;
  logic [15:0] fl_asid;
  logic [38:0] fl_va;

  always #(CLK_PER / 2) clk = ~clk;

  xc_tlb #(.NUM_ENT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_asid(lk_asid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_pte(lk_pte),
    .lk_pte_addr(lk_pte_addr), .fill_en(fill_en), .fill_asid(fill_asid),
    .fill_glb(fill_glb), .fill_lvl(fill_lvl), .fill_va(fill_va),
    .fill_pa(fill_pa), .fill_pte(fill_pte), .fill_pte_addr(fill_pte_addr),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_pte(upd_pte), .fl_en(fl_en),
    .fl_use_asid(fl_use_asid), .fl_asid(fl_asid), .fl_use_va(fl_use_va),
    .fl_va(fl_va)
  );

  int total = 0;
  int bad = 0;

  // reference state
  bit          m_vld [N];
  bit          m_glb [N];
  logic [15:0] m_asid [N];
  logic [38:0] m_tag [N];
  logic [38:0] m_om [N];
  logic [55:0] m_base [N];
  logic [7:0]  m_pte [N];
  logic [55:0] m_pta [N];
  logic [38:0] m_fva [N];
  int          m_age [N];

  function automatic logic [38:0] om_of(input logic [1:0] lvl);
    return (39'd1 << (12 + 9 * int'(lvl))) - 39'd1;
  endfunction

  task automatic report(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_lk(input string tag);
    bit h = 0;
    int k = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && (m_glb[i] || m_asid[i] == lk_asid) &&
          m_tag[i] == (lk_va & ~m_om[i])) begin
        h = 1;
        k = i;
      end
    end
    report(tag, "hit", 64'(lk_hit), 64'(h));
    if (h) begin
      report(tag, "idx", 64'(lk_idx), 64'(k));
      report(tag, "pa", 64'(lk_pa), 64'(m_base[k] | {17'd0, lk_va & m_om[k]}));
      report(tag, "pte", 64'(lk_pte), 64'(m_pte[k]));
      report(tag, "pte_addr", 64'(lk_pte_addr), 64'(m_pta[k]));
    end
  endtask

  task automatic model_step();
    if (fl_en) begin
      for (int i = 0; i < N; i++) begin
        bit va_m = (m_tag[i] == (fl_va & ~m_om[i]));
        bit id_m = !m_glb[i] && (m_asid[i] == fl_asid);
        if (m_vld[i] && (!fl_use_va || va_m) && (!fl_use_asid || id_m))
          m_vld[i] = 0;
      end
    end else if (fill_en) begin
      int v = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) v = i;
      if (v < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) v = i;
      for (int i = 0; i < N; i++) if (i != v && m_age[i] < m_age[v]) m_age[i]++;
      m_age[v]  = 0;
      m_vld[v]  = 1;
      m_glb[v]  = fill_glb;
      m_asid[v] = fill_asid;
      m_om[v]   = om_of(fill_lvl);
      m_tag[v]  = fill_va & ~m_om[v];
      m_base[v] = fill_pa & ~{17'd0, m_om[v]};
      m_pte[v]  = fill_pte;
      m_pta[v]  = fill_pte_addr;
      m_fva[v]  = fill_va;
    end else if (upd_en && m_vld[upd_idx]) begin
      m_pte[upd_idx] = upd_pte;
    end
  endtask

  // check the lookup of this cycle, advance the reference, move to next cycle
  task automatic tick(input string tag);
    #1;
    check_lk(tag);
    model_step();
    @(negedge clk);
    fill_en = 0;
    upd_en  = 0;
    fl_en   = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic [38:0] va);
    lk_asid = a;
    lk_va   = va;
  endtask

  task automatic fill(input logic [15:0] a, input bit g, input logic [1:0] lvl,
                      input logic [38:0] va, input logic [55:0] pa,
                      input logic [7:0] pte, input logic [55:0] pta);
    fill_en = 1; fill_asid = a; fill_glb = g; fill_lvl = lvl;
    fill_va = va; fill_pa = pa; fill_pte = pte; fill_pte_addr = pta;
  endtask

  task automatic flush(input bit ua, input logic [15:0] a,
                       input bit uv, input logic [38:0] va);
    fl_en = 1; fl_use_asid = ua; fl_asid = a; fl_use_va = uv; fl_va = va;
  endtask

  localparam logic [38:0] VA0 = 39'h00_4000_5123;
  localparam logic [38:0] VA1 = 39'h00_8020_1234;
  localparam logic [38:0] VA2 = 39'h00_C123_4567;
  localparam logic [38:0] VA3 = 39'h01_0000_0ABC;
  localparam logic [38:0] VA4 = 39'h01_4000_0FFF;
  localparam logic [38:0] NOWHERE = 39'h7F_FFFF_F000;

  initial begin
    #(CLK_PER * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0;
      m_age[i] = i;
    end
    rst_n = 0;
    fill_en = 0; fill_asid = '0; fill_glb = 0; fill_lvl = '0; fill_va = '0;
    fill_pa = '0; fill_pte = '0; fill_pte_addr = '0;
    upd_en = 0; upd_idx = '0; upd_pte = '0;
    fl_en = 0; fl_use_asid = 0; fl_asid = '0; fl_use_va = 0; fl_va = '0;
    look(16'd1, VA0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    tick("R1");

    // R4: a fill is not seen in its own cycle
    fill(16'd1, 0, 2'd0, VA0, 56'hAB_CDEF_0123_4999, 8'h41, 56'h80_0000_1008);
    look(16'd1, VA0);
    tick("R4");
    look(16'd1, VA0 ^ 39'h0F0);
    tick("R2");
    tick("R12");
    look(16'd2, VA0);
    tick("R3");

    // global 2 MiB page seen from another identifier
    fill(16'd2, 1, 2'd1, VA1, 56'h12_3456_789A_BCDE, 8'hCF, 56'h80_0000_2010);
    tick("R4");
    look(16'd3, VA1 ^ 39'h0_001F_F00F);
    tick("R3");

    // 1 GiB page
    fill(16'd1, 0, 2'd2, VA2, 56'h00_0007_FFFF_FFFF, 8'h0B, 56'h80_0000_3018);
    tick("R4");
    look(16'd1, VA2 ^ 39'h0_3FFF_FFFF);
    tick("R2");
    look(16'd1, VA2 ^ 39'h0_4000_0000);
    tick("R2");

    // fill the table, then the fifth fill evicts the first one
    fill(16'd3, 0, 2'd0, VA3, 56'h00_0000_0BEE_F000, 8'h17, 56'h80_0000_4020);
    tick("R10");
    fill(16'd1, 0, 2'd0, VA4, 56'h00_0000_0CAF_E000, 8'h53, 56'h80_0000_5028);
    look(16'd1, VA0);
    tick("R10");
    look(16'd1, VA0);
    tick("R10");
    look(16'd1, VA4);
    tick("R10");

    // R11: in-place update of slot 0 (now holding VA4)
    upd_en = 1; upd_idx = 2'd0; upd_pte = 8'hC7;
    tick("R11");
    tick("R11");
    upd_en = 1; upd_idx = 2'd0; upd_pte = 8'h01;
    flush(0, '0, 1, NOWHERE);
    tick("R11");
    tick("R11");

    // R7: identifier-only invalidate keeps globals
    flush(1, 16'd1, 0, '0);
    tick("R7");
    look(16'd1, VA1);
    tick("R7");
    look(16'd1, VA2);
    tick("R7");
    look(16'd3, VA3);
    tick("R7");

    // R6: address-only invalidate removes a global entry
    flush(0, '0, 1, VA1 ^ 39'h0_0000_0777);
    look(16'd2, VA1);
    tick("R6");
    tick("R6");

    // R10: refill goes to the lowest free slot
    fill(16'd1, 0, 2'd0, VA0, 56'h00_0000_0DEA_D000, 8'h21, 56'h80_0000_6030);
    tick("R10");
    look(16'd1, VA0);
    tick("R10");
    fill(16'd3, 0, 2'd1, VA2, 56'h00_0000_1A00_0000, 8'h35, 56'h80_0000_7038);
    tick("R10");

    // R8: identifier and address
    flush(1, 16'd3, 1, VA2);
    look(16'd3, VA2);
    tick("R8");
    tick("R8");
    look(16'd3, VA3);
    tick("R8");

    // R9: invalidate beats a fill
    fill(16'd2, 0, 2'd0, VA1, 56'h00_0000_0111_1000, 8'h07, 56'h80_0000_8040);
    flush(0, '0, 1, NOWHERE);
    look(16'd2, VA1);
    tick("R9");
    tick("R9");

    // R5: full invalidate
    flush(0, '0, 0, '0);
    tick("R5");
    look(16'd3, VA3);
    tick("R5");
    look(16'd1, VA0);
    tick("R5");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 19);
      if (op < 5) begin
        int r = $urandom_range(0, 7);
        bit busy = 0;
        for (int i = 0; i < N; i++) if (m_vld[i] && m_fva[i][38:30] == 9'(r)) busy = 1;
        if (!busy) begin
          logic [63:0] p = {$urandom(), $urandom()};
          logic [63:0] q = {$urandom(), $urandom()};
          fill(16'($urandom_range(1, 3)), ($urandom_range(0, 3) == 0),
               2'($urandom_range(0, 2)), {9'(r), 30'($urandom())},
               p[55:0], 8'($urandom()), q[55:0]);
        end
      end else if (op < 7) begin
        int j = $urandom_range(0, N - 1);
        flush($urandom_range(0, 1) == 1, 16'($urandom_range(1, 3)),
              $urandom_range(0, 1) == 1, m_fva[j] ^ 39'($urandom_range(0, 4095)));
      end else if (op < 9) begin
        upd_en = 1;
        upd_idx = 2'($urandom_range(0, N - 1));
        upd_pte = 8'($urandom());
      end
      begin
        int j = $urandom_range(0, N - 1);
        logic [38:0] va = m_fva[j] ^ (39'($urandom()) & 39'h3FFF_FFFF);
        if ($urandom_range(0, 7) == 0) va = {9'($urandom_range(0, 7)), 30'($urandom())};
        look(($urandom_range(0, 1) == 1) ? m_asid[j] : 16'($urandom_range(1, 3)), va);
      end
      tick("R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule